// File: doc/BRIEF.md
# Link Power State Controller

This block decides which power state the upstream serial link of a bridge should be in. Software writes the device power state, the link-control ASPM field and an override enable bit. The block combines these with an idle indication from the transmit and receive paths and gives a requested link state: L0, L0s, L1 or L2. While the link sits in L2, a falling edge on the active-low wake input from the secondary bus produces a one-cycle beacon request toward the upstream link.

Software-directed device states always win over hardware decisions. D1 and D2 map to L1, and D3hot maps to L2, with auxiliary power assumed present. In D0 the link stays in L0 unless hardware-initiated ASPM is allowed. That needs the override enable set and a non-zero ASPM field, and then the link drops after a run of consecutive idle cycles. The electrical signalling, the entry handshakes and the configuration-space decode sit outside this block.

Top module: `link_power_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, linkState is L0 (code 0) and beaconReq is 0. Link codes are L0=0, L0s=1, L1=2, L2=3.
- R2: When devState is D3hot (code 3), linkState is L2 from the next clock edge on, whatever the ASPM inputs are.
- R3: When devState is D1 (code 1) or D2 (code 2), linkState is L1 from the next clock edge on, whatever the ASPM inputs are.
- R4: In D0 (code 0), with aspmGateEn=1 and aspmCtl bit 0 set, linkState becomes L0s at the edge where pathIdle has been sampled high on L0S_IDLE (default 64) consecutive edges. With aspmCtl bit 1 clear, it never goes lower than L0s.
- R5: In D0, with aspmGateEn=1 and aspmCtl bit 1 set, linkState becomes L1 at the edge where pathIdle has been sampled high on L1_IDLE (default 1024) consecutive edges. With aspmCtl=2'b10, the link goes straight from L0 to L1 without passing through L0s.
- R6: In D0, one edge with pathIdle low puts linkState back in L0 at that edge and restarts the idle count from zero.
- R7: When aspmGateEn=0, or when aspmCtl=2'b00, linkState stays at L0 in D0 however long pathIdle stays high.
- R8: While linkState is L2, a falling edge on wakeN passes through a two-flop synchroniser and an edge detector. It drives beaconReq high for exactly one cycle, on the third clock edge after the fall.
- R9: After one beacon, further wakeN falls give no beacon until devState is written to D0. A wakeN fall while linkState is not L2 never gives a beacon.
- R10: Writing D0 while linkState is L2 returns linkState to L0 at the next edge. The idle count restarts only after that edge, so L0s comes L0S_IDLE+1 edges after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devState | input | 2 | Device power state: 0=D0, 1=D1, 2=D2, 3=D3hot |
| aspmCtl | input | 2 | ASPM field: bit0 allows L0s, bit1 allows L1 |
| aspmGateEn | input | 1 | Override enable; 0 vetoes all hardware-initiated ASPM |
| pathIdle | input | 1 | Transmit and receive paths are idle this cycle |
| wakeN | input | 1 | Active-low asynchronous wake request from the secondary bus |
| linkState | output | 2 | Requested link state: 0=L0, 1=L0s, 2=L1, 3=L2 |
| beaconReq | output | 1 | One-cycle beacon request for the upstream link |

## Verification
The idle-driven function is exercised with four ASPM field settings (01, 11, 10, 00) and with the override enable cleared. The 01 and 10 settings show that the two threshold paths are separate. The 11 setting shows that L0s escalates to L1 at the longer count. A busy cycle placed inside an idle run shows that the counter restarts rather than pauses. Device-state writes of D1, D2 and D3hot are made while the link is idle, so they must override ASPM. Wake edges are applied inside L2, again after a beacon, and outside L2, which separates the beacon re-arm rule from the L2 qualification.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;
  typedef enum logic [1:0] {
    DEV_D0    = 2'd0,
    DEV_D1    = 2'd1,
    DEV_D2    = 2'd2,
    DEV_D3HOT = 2'd3
  } devSt_e;

  typedef enum logic [1:0] {
    LNK_L0  = 2'd0,
    LNK_L0S = 2'd1,
    LNK_L1  = 2'd2,
    LNK_L2  = 2'd3
  } lnkSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdle;
    logic fireBeacon;
    logic clrSpent;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic reachShort;
    logic reachLong;
    logic wakeFall;
    logic beaconSpent;
  } dpStatus_t;
endpackage

// File: rtl/lpsc_datapath.sv
module lpsc_datapath
  import lpsc_pkg::*;
#(
  parameter int L0S_IDLE    = 64,
  parameter int L1_IDLE     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pathIdle,
  input  logic       wakeN,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status,
  output logic       beaconReq
);
  localparam int CNT_W = $clog2(L1_IDLE + 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(L0S_IDLE - 1);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(L1_IDLE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(L1_IDLE);

  logic [CNT_W-1:0]     idleCnt;
  logic [SYNC_STAGES:0] wakeSync;
  logic                 beaconSpent;

  // consecutive idle counter, saturating at the long threshold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.clrIdle || !pathIdle) begin
      idleCnt <= '0;
    end else if (idleCnt != CNT_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // synchroniser stages plus one delay stage for the edge detector
  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wakeSync[gi] <= 1'b1;
        end else if (gi == 0) begin
          wakeSync[gi] <= wakeN;
        end else begin
          wakeSync[gi] <= wakeSync[(gi == 0) ? 0 : gi - 1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beaconReq   <= 1'b0;
      beaconSpent <= 1'b0;
    end else begin
      beaconReq <= strobe.fireBeacon;
      if (strobe.fireBeacon) begin
        beaconSpent <= 1'b1;
      end else if (strobe.clrSpent) begin
        beaconSpent <= 1'b0;
      end
    end
  end

  always_comb begin
    status.reachShort  = pathIdle && (idleCnt >= SHORT_M1);
    status.reachLong   = pathIdle && (idleCnt >= LONG_M1);
    status.wakeFall    = wakeSync[SYNC_STAGES] && !wakeSync[SYNC_STAGES-1];
    status.beaconSpent = beaconSpent;
  end
endmodule

// File: rtl/lpsc_control.sv
module lpsc_control
  import lpsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] devState,
  input  logic [1:0] aspmCtl,
  input  logic       aspmGateEn,
  input  logic       pathIdle,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic [1:0] linkState
);
  devSt_e dev;
  lnkSt_e curLink;
  lnkSt_e nextLink;
  logic   aspmOn;

  assign dev     = devSt_e'(devState);
  assign curLink = lnkSt_e'(linkState);

  always_comb begin
    aspmOn = aspmGateEn && (aspmCtl != 2'b00) && (dev == DEV_D0);

    strobe.clrIdle    = !aspmOn || (curLink == LNK_L2);
    strobe.clrSpent   = (dev == DEV_D0);
    strobe.fireBeacon = status.wakeFall && (curLink == LNK_L2) && !status.beaconSpent;

    unique case (dev)
      DEV_D3HOT:      nextLink = LNK_L2;
      DEV_D1, DEV_D2: nextLink = LNK_L1;
      default: begin
        if (curLink == LNK_L2 || !aspmOn || !pathIdle) begin
          nextLink = LNK_L0;
        end else if (aspmCtl[1] && status.reachLong) begin
          nextLink = LNK_L1;
        end else if (aspmCtl[0] && status.reachShort) begin
          nextLink = LNK_L0S;
        end else begin
          nextLink = LNK_L0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkState <= LNK_L0;
    end else begin
      linkState <= nextLink;
    end
  end
endmodule

// File: rtl/link_power_ctrl.sv
module link_power_ctrl
  import lpsc_pkg::*;
#(
  parameter int L0S_IDLE = 64,
  parameter int L1_IDLE  = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] devState,
  input  logic [1:0] aspmCtl,
  input  logic       aspmGateEn,
  input  logic       pathIdle,
  input  logic       wakeN,
  output logic [1:0] linkState,
  output logic       beaconReq
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  lpsc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .devState   (devState),
    .aspmCtl    (aspmCtl),
    .aspmGateEn (aspmGateEn),
    .pathIdle   (pathIdle),
    .status     (status),
    .strobe     (strobe),
    .linkState  (linkState)
  );

  lpsc_datapath #(
    .L0S_IDLE    (L0S_IDLE),
    .L1_IDLE     (L1_IDLE),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pathIdle  (pathIdle),
    .wakeN     (wakeN),
    .strobe    (strobe),
    .status    (status),
    .beaconReq (beaconReq)
  );
endmodule

// File: rtl/link_power_ctrl_checker.sv
module link_power_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] devState,
  input logic [1:0] aspmCtl,
  input logic       aspmGateEn,
  input logic       pathIdle,
  input logic [1:0] linkState,
  input logic       beaconReq
);
  p_d3hot_l2_r2: assert property (@(posedge clk) disable iff (!rstN)
    (devState == 2'd3) |=> (linkState == 2'd3));

  p_d1d2_l1_r3: assert property (@(posedge clk) disable iff (!rstN)
    (devState == 2'd1 || devState == 2'd2) |=> (linkState == 2'd2));

  p_l0s_allowed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 2'd1) |-> $past(aspmCtl[0] && aspmGateEn));

  p_busy_l0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (devState == 2'd0 && !pathIdle) |=> (linkState == 2'd0));

  p_gate_veto_r7: assert property (@(posedge clk) disable iff (!rstN)
    (devState == 2'd0 && !aspmGateEn) |=> (linkState == 2'd0));

  p_beacon_in_l2_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beaconReq) |-> ($past(linkState) == 2'd3));

  p_beacon_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    beaconReq |=> !beaconReq);
endmodule

bind link_power_ctrl link_power_ctrl_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .devState   (devState),
  .aspmCtl    (aspmCtl),
  .aspmGateEn (aspmGateEn),
  .pathIdle   (pathIdle),
  .linkState  (linkState),
  .beaconReq  (beaconReq)
);

// File: tb/link_power_ctrl_bench.sv
`timescale 1ns/1ps
module link_power_ctrl_bench;
  localparam logic [1:0] L0 = 2'd0, L0S = 2'd1, L1 = 2'd2, L2 = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] devState = 2'd0;
  logic [1:0] aspmCtl = 2'b00;
  logic       aspmGateEn = 1'b1;
  logic       pathIdle = 1'b0;
  logic       wakeN = 1'b1;
  logic [1:0] linkState;
  logic       beaconReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    int         cyc;
    logic [1:0] lnk;
    logic       bcn;
    string      tag;
  } exp_t;
  exp_t q[$];

  link_power_ctrl u_link_power_ctrl (
    .clk(clk), .rstN(rstN), .devState(devState), .aspmCtl(aspmCtl),
    .aspmGateEn(aspmGateEn), .pathIdle(pathIdle), .wakeN(wakeN),
    .linkState(linkState), .beaconReq(beaconReq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic want(int d, logic [1:0] l, logic b, string t);
    q.push_back('{cyc + d, l, b, t});
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare queued expectations in the cycle they are due
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (e.cyc != cyc || linkState !== e.lnk || beaconReq !== e.bcn) begin
        bad++;
        $display("FAIL %s: cycle %0d link=%0d beacon=%0d expected link=%0d beacon=%0d",
                 e.tag, cyc, linkState, beaconReq, e.lnk, e.bcn);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    total++;
    if (linkState !== L0 || beaconReq !== 1'b0) begin
      bad++;
      $display("FAIL R1: in reset link=%0d beacon=%0d expected link=0 beacon=0", linkState, beaconReq);
    end
    rstN = 1'b1;
    want(1, L0, 0, "R1");
    tick(2);

    // L0s only
    aspmCtl = 2'b01; pathIdle = 1'b1;
    want(63, L0, 0, "R4");
    want(64, L0S, 0, "R4");
    want(1100, L0S, 0, "R4 stays L0s without bit1");
    tick(1100);
    pathIdle = 1'b0;
    want(1, L0, 0, "R6");
    tick(2);

    // both allowed: escalate
    aspmCtl = 2'b11; pathIdle = 1'b1;
    want(63, L0, 0, "R4");
    want(64, L0S, 0, "R4");
    want(1023, L0S, 0, "R5");
    want(1024, L1, 0, "R5");
    tick(1030);
    pathIdle = 1'b0;
    want(1, L0, 0, "R6");
    tick(1);
    pathIdle = 1'b1;
    want(63, L0, 0, "R6 count restarted");
    want(64, L0S, 0, "R6 count restarted");
    tick(70);

    // L1 only
    pathIdle = 1'b0; aspmCtl = 2'b10;
    tick(1);
    pathIdle = 1'b1;
    want(64, L0, 0, "R5 no L0s");
    want(1023, L0, 0, "R5");
    want(1024, L1, 0, "R5");
    tick(1030);

    // veto paths
    pathIdle = 1'b0; aspmGateEn = 1'b0; aspmCtl = 2'b11;
    tick(1);
    pathIdle = 1'b1;
    want(1100, L0, 0, "R7 gate off");
    tick(1100);
    aspmGateEn = 1'b1; aspmCtl = 2'b00;
    want(200, L0, 0, "R7 field 00");
    tick(200);

    // software states over ASPM
    aspmCtl = 2'b11;
    devState = 2'd1;
    want(1, L1, 0, "R3 D1");
    tick(2);
    devState = 2'd2;
    want(1, L1, 0, "R3 D2");
    tick(2);
    pathIdle = 1'b0; devState = 2'd0;
    want(1, L0, 0, "R6 back to D0");
    tick(2);

    // D3hot and beacon
    devState = 2'd3;
    want(1, L2, 0, "R2");
    tick(3);
    wakeN = 1'b0;
    want(2, L2, 0, "R8");
    want(3, L2, 1, "R8");
    want(4, L2, 0, "R8 single pulse");
    tick(6);
    wakeN = 1'b1;
    tick(5);
    wakeN = 1'b0;
    want(3, L2, 0, "R9 no second beacon");
    want(4, L2, 0, "R9 no second beacon");
    tick(6);

    // leave L2
    devState = 2'd0; aspmCtl = 2'b01; pathIdle = 1'b1;
    want(1, L0, 0, "R10");
    want(64, L0, 0, "R10");
    want(65, L0S, 0, "R10");
    tick(70);
    wakeN = 1'b1;
    tick(5);
    wakeN = 1'b0;
    want(3, L0S, 0, "R9 no beacon outside L2");
    want(4, L0S, 0, "R9 no beacon outside L2");
    tick(6);

    // re-armed after D0
    devState = 2'd3; wakeN = 1'b1;
    want(1, L2, 0, "R2");
    tick(6);
    wakeN = 1'b0;
    want(3, L2, 1, "R9 re-armed");
    tick(6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule